// File: doc/BRIEF.md
# Handshake-Controlled Elastic Pipeline

This block is a chain of processing stages. Each stage has its own local capture enable, and the stages share no common capture edge. Every stage holds a word from its predecessor. It runs a stand-in for variable-latency logic: a down-counter that is loaded when new input appears. When the counter expires, the stage raises a request to store its result, which is the input plus a per-stage constant. The store takes place only on one of that stage's own enable ticks. The stored word then counts as valid input for the next stage, and that flag is the acknowledge between the two stages.

Every local tick is a one-cycle pulse made from the single system clock. Each stage has its own period and phase, so the whole design stays in one clock domain. A request that becomes ready just after a tick has to wait for the next one. A full output register blocks its stage. Stalls from the sink therefore travel back to the source, one stage at a time.

Top module: `elastic_pipe`

## Requirements
- R1: With `rst_n` low at a clock edge, every stage register becomes empty and every stage goes idle. In the cycle after that edge, `snk_valid` and `src_ready` are 0, and every local tick counter starts at zero.
- R2: A word leaves the pipeline as the accepted input plus the sum, over stages k = 0..N_STAGES-1, of STEP_BASE*(k+1), taken modulo 2^DW. With the defaults this sum is 0x0066.
- R3: Words leave in the order in which they were accepted. No word is lost and none is duplicated.
- R4: Stage k's tick is high in cycle n exactly when n mod (TICK_BASE+k) equals k mod (TICK_BASE+k). Cycle 0 is the first cycle after the last reset edge.
- R5: An idle stage whose input is valid in cycle t starts working at the next edge, with a counter of LAT_BASE+k. The counter drops by one each cycle, and the stage's request is up from cycle t+1+LAT_BASE+k.
- R6: A stage captures only in a cycle where its request and its tick are both high. If a request becomes ready one cycle after a tick, the capture comes exactly one local period after that tick.
- R7: A stage captures only if its output register is empty, or is being read in the same cycle. Otherwise the register and its data stay unchanged.
- R8: A captured word counts as valid input for the next stage from the following cycle, and that stage starts its own latency count from there.
- R9: While `snk_ready` is low, `snk_valid` and `snk_data` hold. Stalls then spread backward until `src_ready` stays low.
- R10: `src_ready` is high only in the cycle in which stage 0 captures the source word. The source holds `src_valid` and `src_data` until that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Source word present |
| src_data | input | DW | Source word |
| src_ready | output | 1 | Stage 0 captures the source word this cycle |
| snk_valid | output | 1 | Last stage register holds a word |
| snk_data | output | DW | Word from the last stage |
| snk_ready | input | 1 | Sink takes the word this cycle |

## Verification
A stale latency counter or a wrong tick phase shows first on `src_ready`: it rises in the wrong cycle, which the per-cycle model sees at once. A damaged full flag or a wrong addend reaches the ports once the word has crossed the remaining stages. There it appears as an extra, missing or wrong word at the sink, within a few local periods. The missed-tick case is pinned by checking the exact acceptance cycle on both sides of a stage-0 tick.

// File: rtl/epipe_pkg.sv
// Package epipe_pkg
// Per-stage timing derived from the base parameters of the top.
// Assumes base values are at least 1 for periods and 0 or more for latency.
package epipe_pkg;

    function automatic int stage_period(input int base, input int k);
        return base + k;
    endfunction

    function automatic int stage_phase(input int base, input int k);
        return k % (base + k);
    endfunction

    function automatic int stage_latency(input int base, input int k);
        return base + k;
    endfunction

endpackage

// File: rtl/epipe_tick.sv
// Module epipe_tick
// Makes a one-cycle local enable every PERIOD system cycles, at offset PHASE.
// Assumes PHASE < PERIOD; the counter restarts from zero on reset.
module epipe_tick #(
    parameter int PERIOD = 3,
    parameter int PHASE  = 0
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] phase_cnt;

    // Free-running modulo-PERIOD counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_cnt <= '0;
        else if (phase_cnt == CW'(PERIOD - 1))
            phase_cnt <= '0;
        else
            phase_cnt <= phase_cnt + CW'(1);
    end

    assign tick = (phase_cnt == CW'(PHASE));

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (PERIOD > 1)) |=> !tick); // R4

endmodule

// File: rtl/epipe_stage.sv
// Module epipe_stage
// One pipeline stage: a latency counter stands in for the work time, and
// a request is granted only on the local tick when the output register
// has room. The output valid flag acknowledges the word to the next stage.
// Assumes in_valid and in_data hold until take is high.
module epipe_stage #(
    parameter int             DW      = 16,
    parameter int             LATENCY = 1,
    parameter logic [DW-1:0]  ADDEND  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          take,
    input  logic          consume,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    localparam int LW = (LATENCY > 0) ? $clog2(LATENCY + 1) : 1;

    logic          busy;
    logic [LW-1:0] remain;
    logic          req;

    assign req  = busy && (remain == '0) && in_valid;
    assign take = req && tick && (!out_valid || consume);

    // Work timer: start on fresh input, count down, clear on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (take) begin
            busy   <= 1'b0;
        end else if (in_valid && !busy) begin
            busy   <= 1'b1;
            remain <= LW'(LATENCY);
        end else if (busy && (remain != '0)) begin
            remain <= remain - LW'(1);
        end
    end

    // Output register: load the transformed word, empty it when read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_data  <= in_data + ADDEND;
        end else if (consume) begin
            out_valid <= 1'b0;
        end
    end

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !consume) |=> out_valid); // R7
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !consume) |=> $stable(out_data)); // R7
    AST_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(out_data)); // R6
    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid); // R8
    AST_INPUT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_valid && !take) |=> in_valid); // R3

endmodule

// File: rtl/elastic_pipe.sv
// Module elastic_pipe
// Chain of N_STAGES handshake stages, each with its own local tick.
// Stage k: period TICK_BASE+k, latency LAT_BASE+k, addend STEP_BASE*(k+1).
// Assumes the source holds its word until src_ready.
module elastic_pipe #(
    parameter int N_STAGES  = 3,
    parameter int DW        = 16,
    parameter int TICK_BASE = 3,
    parameter int LAT_BASE  = 1,
    parameter int STEP_BASE = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          src_ready,
    output logic          snk_valid,
    output logic [DW-1:0] snk_data,
    input  logic          snk_ready
);
    import epipe_pkg::*;

    localparam int LAST = N_STAGES - 1;

    logic [N_STAGES-1:0] tick_w;
    logic [N_STAGES-1:0] take_w;
    logic [N_STAGES-1:0] vld_w;
    logic [N_STAGES-1:0] cons_w;
    logic [N_STAGES-1:0] in_v_w;
    logic [DW-1:0]       in_d_w [N_STAGES];
    logic [DW-1:0]       dat_w  [N_STAGES];

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        // Input side: source for stage 0, previous register otherwise.
        if (k == 0) begin : g_head
            assign in_v_w[k] = src_valid;
            assign in_d_w[k] = src_data;
        end else begin : g_body
            assign in_v_w[k] = vld_w[k-1];
            assign in_d_w[k] = dat_w[k-1];
        end

        // Output side: next stage's capture or the sink reads this register.
        if (k == LAST) begin : g_tail
            assign cons_w[k] = snk_ready;
        end else begin : g_mid
            assign cons_w[k] = take_w[k+1];
        end

        epipe_tick #(
            .PERIOD (stage_period(TICK_BASE, k)),
            .PHASE  (stage_phase(TICK_BASE, k))
        ) u_tick (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_w[k])
        );

        epipe_stage #(
            .DW      (DW),
            .LATENCY (stage_latency(LAT_BASE, k)),
            .ADDEND  (DW'(STEP_BASE * (k + 1)))
        ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick_w[k]),
            .in_valid  (in_v_w[k]),
            .in_data   (in_d_w[k]),
            .take      (take_w[k]),
            .consume   (cons_w[k]),
            .out_valid (vld_w[k]),
            .out_data  (dat_w[k])
        );
    end

    assign src_ready = take_w[0];
    assign snk_valid = vld_w[LAST];
    assign snk_data  = dat_w[LAST];

    AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && !src_ready) |=> (src_valid && $stable(src_data))); // R10
    AST_SNK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data))); // R9

endmodule

// File: tb/elastic_pipe_tb_top.sv
// Bench for elastic_pipe: behavioural per-cycle model plus an end-to-end
// word queue, compared in every cycle.
module elastic_pipe_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 3;
    localparam int DW = 16;
    localparam int TB = 3;
    localparam int LB = 1;
    localparam int SB = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          src_ready;
    logic          snk_valid;
    logic [DW-1:0] snk_data;
    logic          snk_ready = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    elastic_pipe #(.N_STAGES(NS), .DW(DW), .TICK_BASE(TB), .LAT_BASE(LB), .STEP_BASE(SB)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .snk_valid(snk_valid), .snk_data(snk_data),
        .snk_ready(snk_ready)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int cyc = 0;
    int last_acc = -1;

    // Model state
    bit            m_v  [NS];
    logic [DW-1:0] m_d  [NS];
    bit            m_st [NS];
    int            m_cnt[NS];
    bit            cur_v = 0;
    logic [DW-1:0] cur_d = '0;
    logic [DW-1:0] q_src[$];
    logic [DW-1:0] q_exp[$];
    logic [DW-1:0] next_word = 16'h0100;

    function automatic logic [DW-1:0] total_add();
        logic [DW-1:0] s = '0;
        for (int k = 0; k < NS; k++) s = s + DW'(SB * (k + 1));
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // One cycle: drive, compare against model, advance model.
    task automatic step(input bit want, input bit rdy);
        bit tk[NS]; bit iv[NS]; bit tkn[NS]; bit cons[NS];
        bit down;
        logic [DW-1:0] ind;
        logic [DW-1:0] got;
        if (!cur_v && want && q_src.size() > 0) begin
            cur_d = q_src.pop_front();
            cur_v = 1;
        end
        src_valid = cur_v;
        src_data  = cur_d;
        snk_ready = rdy;
        #1;
        down = rdy;
        for (int k = NS - 1; k >= 0; k--) begin
            tk[k]   = ((cyc % (TB + k)) == (k % (TB + k)));   // R4
            iv[k]   = (k == 0) ? cur_v : m_v[k-1];
            cons[k] = down;
            tkn[k]  = m_st[k] && (m_cnt[k] == 0) && iv[k] && tk[k] && (!m_v[k] || down);
            down    = tkn[k];
        end
        check(src_ready == tkn[0], "R10 R6 R5 src_ready", int'(src_ready), int'(tkn[0]));
        check(snk_valid == m_v[NS-1], "R9 R7 R8 snk_valid", int'(snk_valid), int'(m_v[NS-1]));
        if (m_v[NS-1])
            check(snk_data == m_d[NS-1], "R2 snk_data", int'(snk_data), int'(m_d[NS-1]));
        if (m_v[NS-1] && rdy) begin
            got = (q_exp.size() > 0) ? q_exp.pop_front() : 'x;
            check(snk_data === got, "R3 R2 order", int'(snk_data), int'(got));
        end
        if (tkn[0]) begin
            q_exp.push_back(cur_d + total_add());
            cur_v = 0;
            last_acc = cyc;
        end
        for (int k = NS - 1; k >= 0; k--) begin
            ind = (k == 0) ? cur_d : m_d[k-1];
            if (k == 0 && tkn[0]) ind = src_data;
            if (tkn[k]) m_st[k] = 0;
            else if (iv[k] && !m_st[k]) begin m_st[k] = 1; m_cnt[k] = LB + k; end
            else if (m_st[k] && m_cnt[k] > 0) m_cnt[k]--;
            if (tkn[k]) begin m_v[k] = 1; m_d[k] = ind + DW'(SB * (k + 1)); end
            else if (cons[k]) m_v[k] = 0;
        end
        cyc++;
        @(negedge clk);
    endtask

    function automatic bit model_empty();
        bit e = !cur_v;
        for (int k = 0; k < NS; k++) if (m_v[k] || m_st[k]) e = 0;
        return e;
    endfunction

    task automatic push_words(input int n);
        for (int i = 0; i < n; i++) begin
            q_src.push_back(next_word);
            next_word = next_word + 16'h0037;
        end
    endtask

    task automatic drain();
        int g = 0;
        while ((!model_empty() || q_src.size() > 0) && g < 2000) begin
            step(1, 1);
            g++;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int t;
        int p0;
        for (int k = 0; k < NS; k++) begin m_v[k] = 0; m_d[k] = '0; m_st[k] = 0; m_cnt[k] = 0; end
        p0 = TB;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state visible at the ports
        check(snk_valid == 1'b0, "R1 snk_valid after reset", int'(snk_valid), 0);
        check(src_ready == 1'b0, "R1 src_ready after reset", int'(src_ready), 0);
        rst_n = 1'b1;
        cyc = 0;

        // Streaming with a free sink
        push_words(20);
        drain();

        // Random gaps and random backpressure
        push_words(60);
        while (q_src.size() > 0 || cur_v)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0);
        drain();

        // Long sink stall: backpressure must reach the source (R9)
        push_words(10);
        for (int i = 0; i < 40; i++) step(1, 0);
        check(src_ready == 1'b0, "R9 src_ready under full stall", int'(src_ready), 0);
        drain();
        check(q_exp.size() == 0, "R3 words outstanding", q_exp.size(), 0);

        // R6: request ready exactly on a stage-0 tick
        while (((cyc + 1 + LB) % p0) != 0) step(0, 1);
        t = cyc;
        push_words(1);
        drain();
        check(last_acc == t + 1 + LB, "R6 R5 accept on tick", last_acc, t + 1 + LB);

        // R6: request ready one cycle after a tick: one full local period later
        while (((cyc + LB) % p0) != 0) step(0, 1);
        t = cyc;
        push_words(1);
        drain();
        check(last_acc == t + LB + p0, "R6 missed tick delay", last_acc, t + LB + p0);
        check(q_exp.size() == 0, "R3 words outstanding at end", q_exp.size(), 0);

        finished = 1;
        summary();
        $finish;
    end

endmodule